// File: doc/BRIEF.md
# Decorrelated LFSR Random Word Generator

This block produces a 30-bit pseudo-random word on every enabled clock cycle. It uses a Fibonacci shift register: each step moves the state one place toward the most significant bit and feeds the XOR of the tapped bits back in at bit 0. Software or a neighbouring block picks one of three tap masks at run time through a 2-bit select. A seed can be loaded to start a reproducible sequence. Lock-up protection means a zero state is never kept: it is replaced with a fixed non-zero value.

A shift register's consecutive words are strongly correlated, because each word is the previous one shifted by one place. An optional mapping stage swaps every even/odd bit pair of the output word to weaken that relation. The output word and its valid flag are registered, and they change on the same clock edge as the internal state.

Top module: `rng_word_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state and `word_o` become all ones (0x3FFFFFFF) and `valid_o` becomes 0.
- R2: With `tap_sel` = 0 and `en` = 1, each edge moves the state to {state[28:0], fb}, where fb is the XOR of state bits 29, 5, 3 and 0 (mask 0x20000029).
- R3: `tap_sel` = 1 selects mask 0x2000005E and `tap_sel` = 2 selects mask 0x20000089. `tap_sel` = 3 behaves exactly like 0. In every case, fb is the XOR of the state bits whose mask bit is set.
- R4: When `en` and `seed_load` are both low, the state and `word_o` keep their values and `valid_o` is 0 after the edge.
- R5: `seed_load` = 1 with a non-zero `seed_i` sets the state to `seed_i` at the edge, whatever `en` is. That cycle counts as a produced word.
- R6: A zero seed load, or any zero state, is replaced at the next edge by the recovery value 0x00000001. A zero state never holds for two consecutive cycles.
- R7: `word_o` is the new state when `map_en` = 0. When `map_en` = 1, it is the new state with bits 2k and 2k+1 exchanged for k = 0..14.
- R8: `valid_o` is 1 after every edge where a load or an enabled shift took place. A change of `tap_sel` while idle leaves the state unchanged and applies from the next shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance the register by one step |
| seed_i | input | 30 | Seed value |
| seed_load | input | 1 | Load `seed_i` this cycle (overrides the shift) |
| tap_sel | input | 2 | Tap mask select: 0 and 3 = 0x20000029, 1 = 0x2000005E, 2 = 0x20000089 |
| map_en | input | 1 | Enable the pair-swap output mapping |
| word_o | output | 30 | Registered output word |
| valid_o | output | 1 | A new word was produced at the last edge |

## Verification
The bench runs long enabled stretches under each tap select, including the aliased code 3, against an independent model. A wrong tap position or a swapped shift direction shows up as the sequences diverging within a few words. It loads a zero seed to confirm recovery to 0x00000001; a design without lock-up protection would stay stuck at zero. It also loads alternating-bit seeds with mapping on and off, which exposes a swap that moves the wrong bits. Finally, it changes the select while idle and while shifting, which catches a design that disturbs the state when the taps change or applies the new taps late.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int RNG_W = 30;

  typedef enum logic [1:0] {
    TAPS_PRIMARY = 2'd0,
    TAPS_ALT1    = 2'd1,
    TAPS_ALT2    = 2'd2,
    TAPS_SPARE   = 2'd3
  } tap_code_e;
endpackage

// File: rtl/rng_tap_select.sv
module rng_tap_select #(
  parameter int              W      = rng_pkg::RNG_W,
  parameter logic [W-1:0]    MASK_A = 30'h20000029,
  parameter logic [W-1:0]    MASK_B = 30'h2000005E,
  parameter logic [W-1:0]    MASK_C = 30'h20000089
) (
  input  logic [1:0]   sel,
  output logic [W-1:0] mask
);
  import rng_pkg::*;

  always_comb begin
    unique case (tap_code_e'(sel))
      TAPS_ALT1: mask = MASK_B;
      TAPS_ALT2: mask = MASK_C;
      default:   mask = MASK_A;
    endcase
  end
endmodule

// File: rtl/rng_lfsr_core.sv
module rng_lfsr_core #(
  parameter int           W         = rng_pkg::RNG_W,
  parameter logic [W-1:0] RECOVER   = {{(W-1){1'b0}}, 1'b1},
  parameter logic [W-1:0] RESET_VAL = {W{1'b1}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic [W-1:0] mask,
  output logic [W-1:0] state_q,
  output logic [W-1:0] state_d,
  output logic         advance
);
  logic         fb;
  logic [W-1:0] cand;
  logic         lockup;
  logic         started;

  always_comb begin
    fb = ^(state_q & mask);
    if (load)         cand = seed;
    else if (step_en) cand = {state_q[W-2:0], fb};
    else              cand = state_q;
    lockup  = (cand == '0);
    state_d = lockup ? RECOVER : cand;
    advance = load | step_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RESET_VAL;
      started <= 1'b1;
    end else begin
      state_q <= state_d;
    end
  end

  // R6
  nonzero_state_chk: assert property (@(posedge clk) disable iff (rst)
    started |-> (state_q != '0));

  // R4
  hold_state_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !step_en && !load) |=> $stable(state_q));

  // R2
  shift_dir_chk: assert property (@(posedge clk) disable iff (rst)
    (started && step_en && !load && state_q != '0) |=>
      (state_q[W-1:1] == $past(state_q[W-2:0])));

  // R5
  seed_load_chk: assert property (@(posedge clk) disable iff (rst)
    (started && load && seed != '0) |=> (state_q == $past(seed)));
endmodule

// File: rtl/rng_pair_swap.sv
module rng_pair_swap #(
  parameter int W = rng_pkg::RNG_W
) (
  input  logic         swap_en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int PAIRS = W / 2;

  logic [W-1:0] swapped;

  for (genvar k = 0; k < PAIRS; k++) begin : g_pair
    assign swapped[2*k]   = din[2*k+1];
    assign swapped[2*k+1] = din[2*k];
  end

  if ((W % 2) != 0) begin : g_odd
    assign swapped[W-1] = din[W-1];
  end

  assign dout = swap_en ? swapped : din;
endmodule

// File: rtl/rng_word_gen.sv
module rng_word_gen #(
  parameter int              W      = rng_pkg::RNG_W,
  parameter logic [W-1:0]    MASK_A = 30'h20000029,
  parameter logic [W-1:0]    MASK_B = 30'h2000005E,
  parameter logic [W-1:0]    MASK_C = 30'h20000089
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] seed_i,
  input  logic         seed_load,
  input  logic [1:0]   tap_sel,
  input  logic         map_en,
  output logic [W-1:0] word_o,
  output logic         valid_o
);
  logic [W-1:0] mask;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         advance;
  logic [W-1:0] mapped;
  logic         started;

  rng_tap_select #(.W(W), .MASK_A(MASK_A), .MASK_B(MASK_B), .MASK_C(MASK_C)) u_taps (
    .sel  (tap_sel),
    .mask (mask)
  );

  rng_lfsr_core #(.W(W)) u_core (
    .clk     (clk),
    .rst     (rst),
    .step_en (en),
    .load    (seed_load),
    .seed    (seed_i),
    .mask    (mask),
    .state_q (state_q),
    .state_d (state_d),
    .advance (advance)
  );

  rng_pair_swap #(.W(W)) u_map (
    .swap_en (map_en),
    .din     (state_d),
    .dout    (mapped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= {W{1'b1}};
      valid_o <= 1'b0;
      started <= 1'b1;
    end else begin
      valid_o <= advance;
      if (advance) word_o <= mapped;
    end
  end

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (started && (en || seed_load)) |=> valid_o);

  // R4
  idle_word_chk: assert property (@(posedge clk) disable iff (rst)
    (started && !en && !seed_load) |=> (!valid_o && $stable(word_o)));

  // R7
  raw_word_chk: assert property (@(posedge clk) disable iff (rst)
    (started && (en || seed_load) && !map_en) |=> (word_o == state_q));
endmodule

// File: tb/sim_rng_word_gen.sv
`timescale 1ns/1ps
module sim_rng_word_gen;
  localparam int W = 30;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b0;
  logic [W-1:0] seed_i = '0;
  logic         seed_load = 1'b0;
  logic [1:0]   tap_sel = 2'd0;
  logic         map_en = 1'b0;
  logic [W-1:0] word_o;
  logic         valid_o;

  int checks = 0;
  int failures = 0;

  logic [W-1:0] m_state;
  logic [W-1:0] m_word;

  always #2 clk = ~clk;

  rng_word_gen u0 (
    .clk(clk), .rst(rst), .en(en), .seed_i(seed_i), .seed_load(seed_load),
    .tap_sel(tap_sel), .map_en(map_en), .word_o(word_o), .valid_o(valid_o)
  );

  function automatic logic [W-1:0] tap_of(input logic [1:0] s);
    case (s)
      2'd1:    return 30'h2000005E;
      2'd2:    return 30'h20000089;
      default: return 30'h20000029;
    endcase
  endfunction

  function automatic logic [W-1:0] pairswap(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int k = 0; k < W/2; k++) begin
      r[2*k]   = v[2*k+1];
      r[2*k+1] = v[2*k];
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive, clock, update model, compare
  task automatic step(input logic e, input logic ld, input logic [W-1:0] sd,
                      input logic [1:0] ts, input logic mp, input string tag);
    logic adv;
    @(negedge clk);
    en = e; seed_load = ld; seed_i = sd; tap_sel = ts; map_en = mp;
    adv = e | ld;
    if (ld)     m_state = (sd == '0) ? 30'h1 : sd;
    else if (e) m_state = {m_state[W-2:0], ^(m_state & tap_of(ts))};
    if (adv) m_word = mp ? pairswap(m_state) : m_state;
    @(posedge clk);
    #1;
    check(word_o === m_word, tag, word_o, m_word);
    check(valid_o === adv, {tag, " valid"}, W'(valid_o), W'(adv));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    m_state = '1; m_word = '1;
    check(word_o === 30'h3FFFFFFF, "R1 reset word", word_o, 30'h3FFFFFFF);
    check(valid_o === 1'b0, "R1 reset valid", W'(valid_o), '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_taps(input logic [1:0] ts, input string tag);
    step(1'b0, 1'b1, 30'h0123ABCD, ts, 1'b0, {tag, " seed"});
    for (int i = 0; i < 300; i++) step(1'b1, 1'b0, '0, ts, 1'b0, tag);
  endtask

  task automatic t_hold();
    step(1'b1, 1'b0, '0, 2'd0, 1'b0, "R4 pre");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 30'h155, 2'd0, 1'b1, "R4 hold");
    step(1'b1, 1'b0, '0, 2'd0, 1'b0, "R4 resume");
  endtask

  task automatic t_load();
    step(1'b1, 1'b1, 30'h2AAA5555, 2'd0, 1'b0, "R5 load over shift");
    step(1'b0, 1'b1, 30'h00000001, 2'd1, 1'b0, "R5 load min");
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, '0, 2'd1, 1'b0, "R5 run from seed");
  endtask

  task automatic t_zero();
    step(1'b0, 1'b1, '0, 2'd0, 1'b0, "R6 zero seed");
    check(word_o === 30'h1, "R6 recovery value", word_o, 30'h1);
    step(1'b1, 1'b1, '0, 2'd2, 1'b0, "R6 zero seed with en");
    for (int i = 0; i < 40; i++) begin
      step(1'b1, 1'b0, '0, 2'd2, 1'b0, "R6 run");
      check(word_o !== '0, "R6 nonzero", word_o, 30'h1);
    end
  endtask

  task automatic t_map();
    step(1'b0, 1'b1, 30'h15555555, 2'd0, 1'b1, "R7 map alt");
    check(word_o === 30'h2AAAAAAA, "R7 swap even/odd", word_o, 30'h2AAAAAAA);
    step(1'b0, 1'b1, 30'h15555555, 2'd0, 1'b0, "R7 map off");
    step(1'b0, 1'b1, 30'h00000003, 2'd0, 1'b1, "R7 pair 0 fixed");
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, '0, 2'(i % 3), 1'b1, "R7 mapped run");
  endtask

  task automatic t_switch();
    step(1'b0, 1'b1, 30'h3A5C1234, 2'd0, 1'b0, "R8 seed");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0, 2'd0, 1'b0, "R8 taps0");
    step(1'b0, 1'b0, '0, 2'd2, 1'b0, "R8 idle select change");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0, 2'd2, 1'b0, "R8 taps2");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, '0, 2'(i % 4), 1'b0, "R8 live switch");
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_taps(2'd0, "R2 taps0");
    t_taps(2'd1, "R3 taps1");
    t_taps(2'd2, "R3 taps2");
    t_taps(2'd3, "R3 taps3 alias");
    t_hold();
    t_load();
    t_zero();
    t_map();
    t_switch();
    t_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule